// File: doc/BRIEF.md
# BCD Digit Latch and Seven-Segment Decoder

This block captures a 4-bit 8421 BCD digit into a clocked storage register and turns the stored digit into seven active-high segment drive lines. Three controls shape the result. A hold input freezes the stored digit. An active-low blank input darkens the display. An active-low test input lights every segment. The register keeps the digit code, not the decoded pattern, so test and blank act on top of whatever digit is held. Clearing test or blank brings that digit back at once.

The controls have a fixed priority: lamp test first, then blanking, then the data path. The data path shows the ten decimal digits and shows nothing for the six codes above nine. An optional dimming generator can also force blanking for part of every period, to set the display brightness. It is an N-bit counter compared against a duty setting. Its request is combined with the external blank input, so either one can darken the display.

The register and the dimming counter advance only on clock edges where the clock enable is high. Reset is asserted asynchronously and released through a short synchronizer. Segment lines are combinational from the stored code and the control inputs.

Top module: `seg_latch_top`

## Requirements
- R1: On a rising clock edge with `ce_i` high and `hold_i` low, the stored digit takes the value of `code_i`, and `seg_o` shows it from that edge onward.
- R2: On an edge with `hold_i` high or `ce_i` low, the stored digit keeps its value, so changes on `code_i` leave `seg_o` unchanged.
- R3: While `test_ni` is low, `seg_o` is 7'h7F, whatever the blank, dimming, hold and data inputs are.
- R4: While `test_ni` is high and `blank_ni` is low, `seg_o` is 7'h00, whatever the stored digit is.
- R5: With test and blanking inactive, the digits map to `seg_o` (bit 6 = segment a, bit 0 = segment g) as 0→7E, 1→30, 2→6D, 3→79, 4→33, 5→5B, 6→1F, 7→70, 8→7F, 9→73, all in hex. Digit 6 has no top segment and digit 9 has no bottom segment.
- R6: Stored codes 10 to 15 give `seg_o` = 7'h00.
- R7: After reset the stored digit is 0, so with the controls inactive `seg_o` is 7'h7E until the first load.
- R8: When dimming is enabled, a DIM_W-bit counter advances on each enabled edge. The display is blanked while the counter value is at or above `duty_i` (DIM_W+1 bits wide). Over any 2^DIM_W consecutive enabled cycles the digit is therefore lit in exactly min(`duty_i`, 2^DIM_W) of them. A `duty_i` of 2^DIM_W never dims, and lamp test still lights every segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_i | input | 1 | Clock enable for the digit register and the dimming counter |
| hold_i | input | 1 | High freezes the stored digit; low lets it load |
| code_i | input | 4 | BCD digit input |
| blank_ni | input | 1 | Active-low display blanking |
| test_ni | input | 1 | Active-low lamp test |
| duty_i | input | DIM_W+1 | Lit cycles per dimming period |
| seg_o | output | 7 | Segments a..g on bits 6..0, active high |

## Verification
The assertions assume that `rst_ni` is low from time zero until a few clock edges have passed. They also assume that every input changes away from the rising edge, so the value sampled at an edge is the value that was settled before it. The bench drives all inputs on the falling edge and holds reset over several cycles. The dimming checks count lit cycles over one whole period instead of relying on the counter phase, which the reset synchronizer leaves unspecified to the bench. These checks keep `ce_i` high throughout.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;

  typedef logic [CODE_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0]  seg_t;

  localparam seg_t SEG_ALL_ON  = '1;
  localparam seg_t SEG_ALL_OFF = '0;

  // bit 6 = segment a ... bit 0 = segment g
  function automatic seg_t bcd_to_seg(input bcd_t digit);
    seg_t pat;
    case (digit)
      4'd0:    pat = 7'b1111110;
      4'd1:    pat = 7'b0110000;
      4'd2:    pat = 7'b1101101;
      4'd3:    pat = 7'b1111001;
      4'd4:    pat = 7'b0110011;
      4'd5:    pat = 7'b1011011;
      4'd6:    pat = 7'b0011111;
      4'd7:    pat = 7'b1110000;
      4'd8:    pat = 7'b1111111;
      4'd9:    pat = 7'b1110011;
      default: pat = SEG_ALL_OFF;
    endcase
    return pat;
  endfunction
endpackage

// File: rtl/seg_code_reg.sv
module seg_code_reg
  import seg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic hold_i,
  input  bcd_t code_i,
  output bcd_t code_o
);
  bcd_t code_q, code_d;
  logic load;

  always_comb begin
    load   = ce_i && !hold_i;
    code_d = code_q;
    if (load) code_d = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/seg_dim_gen.sv
module seg_dim_gen #(
  parameter bit DIM_EN = 1'b1,
  parameter int DIM_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic [DIM_W:0]   duty_i,
  output logic [DIM_W-1:0] cnt_o,
  output logic             blank_o
);
  generate
    if (DIM_EN) begin : g_dim
      logic [DIM_W-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (ce_i) cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end

      assign cnt_o   = cnt_q;
      assign blank_o = ({1'b0, cnt_q} >= duty_i);
    end else begin : g_nodim
      logic unused_in;
      assign unused_in = ^{clk_i, rst_ni, ce_i, duty_i};
      assign cnt_o     = '0;
      assign blank_o   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/seg_out_sel.sv
module seg_out_sel
  import seg_pkg::*;
(
  input  bcd_t code_i,
  input  logic test_ni,
  input  logic blank_ni,
  input  logic dim_blank_i,
  output seg_t seg_o
);
  always_comb begin
    if (!test_ni)                      seg_o = SEG_ALL_ON;
    else if (!blank_ni || dim_blank_i) seg_o = SEG_ALL_OFF;
    else                               seg_o = bcd_to_seg(code_i);
  end
endmodule

// File: rtl/seg_latch_top.sv
module seg_latch_top
  import seg_pkg::*;
#(
  parameter bit DIM_EN      = 1'b1,
  parameter int DIM_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             hold_i,
  input  logic [3:0]       code_i,
  input  logic             blank_ni,
  input  logic             test_ni,
  input  logic [DIM_W:0]   duty_i,
  output logic [6:0]       seg_o
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] sync_q;
  logic              rst_sync_n;
  bcd_t              code_q;
  logic [DIM_W-1:0]  dim_cnt;
  logic              dim_blank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_MSB];

  seg_code_reg i_code_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .ce_i   (ce_i),
    .hold_i (hold_i),
    .code_i (code_i),
    .code_o (code_q)
  );

  seg_dim_gen #(.DIM_EN(DIM_EN), .DIM_W(DIM_W)) i_dim_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .ce_i    (ce_i),
    .duty_i  (duty_i),
    .cnt_o   (dim_cnt),
    .blank_o (dim_blank)
  );

  seg_out_sel i_out_sel (
    .code_i      (code_q),
    .test_ni     (test_ni),
    .blank_ni    (blank_ni),
    .dim_blank_i (dim_blank),
    .seg_o       (seg_o)
  );
endmodule

// File: rtl/seg_latch_chk.sv
module seg_latch_chk #(
  parameter bit DIM_EN = 1'b1,
  parameter int DIM_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_sync_n,
  input logic             ce_i,
  input logic             hold_i,
  input logic [3:0]       code_i,
  input logic             blank_ni,
  input logic             test_ni,
  input logic [DIM_W:0]   duty_i,
  input logic [3:0]       code_q,
  input logic [DIM_W-1:0] dim_cnt,
  input logic             dim_blank,
  input logic [6:0]       seg_o
);
  assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (ce_i && !hold_i) |=> (code_q == $past(code_i)));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (hold_i || !ce_i) |=> $stable(code_q));

  assert_test_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_ni |-> (seg_o == 7'h7F));

  assert_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_ni && !blank_ni) |-> (seg_o == 7'h00));

  assert_illegal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_ni && code_q > 4'd9) |-> (seg_o == 7'h00));

  assert_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_sync_n) |-> (code_q == 4'd0));

  generate
    if (DIM_EN) begin : g_dim_chk
      assert_dim_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (test_ni && ({1'b0, dim_cnt} >= duty_i)) |-> (seg_o == 7'h00));
      assert_dimstep_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        ce_i |=> (dim_cnt == $past(dim_cnt) + 1'b1));
    end
  endgenerate

  logic unused_chk;
  assign unused_chk = ^{blank_ni, dim_blank};
endmodule

bind seg_latch_top seg_latch_chk #(.DIM_EN(DIM_EN), .DIM_W(DIM_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_sync_n (rst_sync_n),
  .ce_i       (ce_i),
  .hold_i     (hold_i),
  .code_i     (code_i),
  .blank_ni   (blank_ni),
  .test_ni    (test_ni),
  .duty_i     (duty_i),
  .code_q     (code_q),
  .dim_cnt    (dim_cnt),
  .dim_blank  (dim_blank),
  .seg_o      (seg_o)
);

// File: tb/test_seg_latch_top.sv
module test_seg_latch_top;
  localparam int PERIOD = 10;
  localparam int DIM_W  = 3;
  localparam int FULL   = 1 << DIM_W;

  logic           clk = 1'b0;
  logic           rst_n, ce, hold, blank_n, test_n;
  logic [3:0]     code;
  logic [DIM_W:0] duty;
  logic [6:0]     seg;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] m_code = 4'd0;
  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  seg_latch_top #(.DIM_EN(1'b1), .DIM_W(DIM_W), .SYNC_STAGES(2)) i_seg_latch_top (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .hold_i(hold), .code_i(code),
    .blank_ni(blank_n), .test_ni(test_n), .duty_i(duty), .seg_o(seg)
  );

  function automatic logic [6:0] digit_pat(input logic [3:0] c);
    logic [6:0] p;
    case (c)
      4'd0: p = 7'h7E; 4'd1: p = 7'h30; 4'd2: p = 7'h6D; 4'd3: p = 7'h79;
      4'd4: p = 7'h33; 4'd5: p = 7'h5B; 4'd6: p = 7'h1F; 4'd7: p = 7'h70;
      4'd8: p = 7'h7F; 4'd9: p = 7'h73; default: p = 7'h00;
    endcase
    return p;
  endfunction

  function automatic logic [6:0] model(input logic [3:0] c, input logic t, input logic b);
    if (!t)      return 7'h7F;
    else if (!b) return 7'h00;
    else         return digit_pat(c);
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: seg actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic h, input logic b,
                       input logic t, input logic e, input string tag);
    @(negedge clk);
    code = c; hold = h; blank_n = b; test_n = t; ce = e;
    if (!h && e) m_code = c;
    exp_q.push_back(model(m_code, t, b));
    tag_q.push_back(tag);
  endtask

  // monitor: compares one queued item a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (exp_q.size() > 0) check(tag_q.pop_front(), seg, exp_q.pop_front());
    end
  end

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce = 1'b1; hold = 1'b1; code = 4'd9;
    blank_n = 1'b1; test_n = 1'b1; duty = DIM_W'(0) + (DIM_W+1)'(FULL);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: held register shows digit 0 after reset
    drive(4'd9, 1'b1, 1'b1, 1'b1, 1'b1, "R7");

    // sweep every code under all test/blank combinations
    for (int c = 0; c < 16; c++) begin
      drive(4'(c), 1'b0, 1'b1, 1'b1, 1'b1, (c > 9) ? "R6" : "R5 R1");
      for (int t = 0; t < 2; t++) begin
        for (int b = 0; b < 2; b++) begin
          drive(4'(c), 1'b0, 1'(b), 1'(t), 1'b1,
                (t == 0) ? "R3" : (b == 0) ? "R4" : (c > 9) ? "R6" : "R5");
        end
      end
    end

    // R2: hold keeps the digit
    drive(4'd5, 1'b0, 1'b1, 1'b1, 1'b1, "R1");
    for (int c = 0; c < 16; c++) drive(4'(c), 1'b1, 1'b1, 1'b1, 1'b1, "R2");
    drive(4'd3, 1'b0, 1'b1, 1'b1, 1'b0, "R2 ce low");
    drive(4'd3, 1'b1, 1'b1, 1'b0, 1'b1, "R3 over held");
    drive(4'd3, 1'b1, 1'b0, 1'b1, 1'b1, "R4 over held");
    drive(4'd3, 1'b1, 1'b1, 1'b1, 1'b1, "R2 after controls");
    drive(4'd6, 1'b0, 1'b1, 1'b1, 1'b1, "R5 six");
    drive(4'd9, 1'b0, 1'b1, 1'b1, 1'b1, "R5 nine");
    drive(4'd8, 1'b0, 1'b1, 1'b1, 1'b1, "R1 eight");
    repeat (3) @(posedge clk);

    // R8: dimming duty over one full counter period
    for (int k = 0; k < 4; k++) begin
      int d;
      int lit;
      d = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 5 : FULL;
      @(negedge clk);
      duty = (DIM_W+1)'(d);
      lit = 0;
      for (int s = 0; s < FULL; s++) begin
        @(posedge clk);
        #(PERIOD/4);
        if (seg == 7'h7F) lit++;
        else if (seg != 7'h00) begin
          n_bad++;
          $display("FAIL R8: seg actual %h expected 7f or 00", seg);
        end
      end
      n_cmp++;
      if (lit != d) begin
        n_bad++;
        $display("FAIL R8: lit cycles actual %0d expected %0d", lit, d);
      end
    end

    // R8/R3: lamp test overrides dimming at duty 0
    @(negedge clk);
    duty = '0; test_n = 1'b0;
    @(posedge clk); #(PERIOD/4);
    check("R8 R3 test over dim", seg, 7'h7F);
    @(negedge clk);
    test_n = 1'b1;
    @(posedge clk); #(PERIOD/4);
    check("R8 dim duty 0", seg, 7'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule